// File: doc/BRIEF.md
# Timer Control Clear Guard

This block sits next to a timer bank's control register and governs one way of changing it: a clear register that drops selected control bits. Every timer owns a group of control bits whose lowest bit is its run enable. A write to the clear register produces a clear mask and the control word that results from it. It also produces a per-timer stop pulse for each running timer whose enable bit is being dropped. The surrounding logic applies the stop pulse before any other change to that timer, just as it does for an ordinary control write.

In protected mode the clear register only acts after an unlock command has been written to a separate lock register. The command byte sits one bit up in the write data, and a second command locks the register again. In open mode the lock register does not exist and clears always act. In that mode an interrupt status register is also reachable over the bus. Each timer's interrupt event sets one status bit, and a write ANDs its data into the status.

Top module: `timer_ctl_guard`

## Requirements
- R1: After reset the clear function is locked, all interrupt status bits are 0, and a read of the lock register returns 0.
- R2: In protected mode a write to offset 0x38 whose data bits [8:1] equal 0xAE unlocks the clear function from the next cycle on. `lock_open` goes to 1 and a read of 0x38 returns 1.
- R3: In protected mode a write to offset 0x38 whose data bits [8:1] equal 0xEA locks the clear function from the next cycle on.
- R4: A lock register write with any other command leaves the lock state unchanged. This includes the codes placed in data bits [7:0].
- R5: A read of 0x38 returns the lock state in bit 0, and 0 in every other bit.
- R6: In protected mode, a write to 0x3C in the same cycle drives `clr_mask` equal to the write data and `ctrl_next = ctrl_q & ~wdata`, but only while unlocked. While locked, `clr_mask` is 0 and `ctrl_next` equals `ctrl_q`.
- R7: During an accepted clear, `tmr_stop[i]` is 1 exactly when control bit 4*i (timer i's enable) is 1 both in `ctrl_q` and in the write data.
- R8: In open mode every write to 0x3C takes effect, and `lock_open` is always 1.
- R9: In open mode a read of 0x34 returns the status in bits [N-1:0], and a write to 0x34 ANDs its data bits into the status.
- R10: An event on `irq_evt[i]` sets status bit i in the next cycle, even if a status write clears that bit in the same cycle. Status bits are never set without an event.
- R11: In protected mode offset 0x34 reads 0 and writes to it leave the status unchanged. In open mode offset 0x38 reads 0 and writes to it have no effect.
- R12: Reads of any other offset return 0, and `rd_data` is 0 while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | AW | Byte offset of the access |
| wdata | input | DW | Write data |
| rd_data | output | DW | Read data, combinational on rd_en and addr |
| ctrl_q | input | N_TMR*CTL_BITS | Present control register value |
| irq_evt | input | N_TMR | Per-timer interrupt event pulses |
| clr_mask | output | N_TMR*CTL_BITS | Bits cleared by this cycle's write |
| ctrl_next | output | N_TMR*CTL_BITS | Control value after the clear |
| tmr_stop | output | N_TMR | Per-timer disable pulse of an accepted clear |
| lock_open | output | 1 | Clear function currently allowed |
| irq_sts | output | N_TMR | Interrupt status |

## Verification
The assertions assume that `ctrl_q` is the control register the block feeds and that it holds steady within a cycle. They also assume that event pulses and bus strobes are sampled only on rising edges. The bench drives every input on the falling edge and keeps it until the next falling edge, so each access occupies exactly one cycle. Collisions between an event and a status write on the same bit are created on purpose to exercise the set-wins rule.

// File: rtl/timer_guard_pkg.sv
package timer_guard_pkg;

  typedef enum logic [1:0] {
    LK_NONE = 2'd0,
    LK_OPEN = 2'd1,
    LK_SHUT = 2'd2
  } lock_op_e;

  // command byte sits one bit above the bottom of the write data
  function automatic logic [7:0] guard_cmd(input logic [8:0] low_bits);
    return low_bits[8:1];
  endfunction

  function automatic lock_op_e guard_decode(input logic [7:0] cmd,
                                            input logic [7:0] open_code,
                                            input logic [7:0] shut_code);
    if (cmd == open_code) return LK_OPEN;
    if (cmd == shut_code) return LK_SHUT;
    return LK_NONE;
  endfunction

endpackage

// File: rtl/timer_clr_lock.sv
module timer_clr_lock
  import timer_guard_pkg::*;
#(
  parameter logic [7:0] OPEN_CODE = 8'hAE,
  parameter logic [7:0] SHUT_CODE = 8'hEA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lock_wr,
  input  logic [8:0] wdata_lo,
  output logic       unlocked_q
);

  logic [7:0] cmd;
  lock_op_e   lock_op;

  assign cmd     = guard_cmd(wdata_lo);
  assign lock_op = lock_wr ? guard_decode(cmd, OPEN_CODE, SHUT_CODE) : LK_NONE;

  always_ff @(posedge clk) begin
    if (!rst_n)                   unlocked_q <= 1'b0;
    else if (lock_op == LK_OPEN)  unlocked_q <= 1'b1;
    else if (lock_op == LK_SHUT)  unlocked_q <= 1'b0;
  end

  assert_unlock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_wr && wdata_lo[8:1] == OPEN_CODE) |=> unlocked_q);

  assert_relock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_wr && wdata_lo[8:1] == SHUT_CODE) |=> !unlocked_q);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_wr || (wdata_lo[8:1] != OPEN_CODE && wdata_lo[8:1] != SHUT_CODE))
      |=> $stable(unlocked_q));

endmodule

// File: rtl/timer_irq_sts.sv
module timer_irq_sts #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sts_wr,
  input  logic [N-1:0] wmask,
  input  logic [N-1:0] irq_evt,
  output logic [N-1:0] sts_q
);

  logic [N-1:0] kept;

  assign kept = sts_wr ? (sts_q & wmask) : sts_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= kept | irq_evt;
  end

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_evt) |=> ((sts_q & $past(irq_evt)) == $past(irq_evt)));

  assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts_q & ~$past(sts_q) & ~$past(irq_evt)) == '0));

  assert_and_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && !(|irq_evt)) |=> ((sts_q & ~$past(wmask)) == '0));

endmodule

// File: rtl/timer_clr_apply.sv
module timer_clr_apply #(
  parameter int N  = 8,
  parameter int CB = 4,
  localparam int CW = N * CB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_wr,
  input  logic          unlocked,
  input  logic [CW-1:0] wbits,
  input  logic [CW-1:0] ctrl_q,
  output logic [CW-1:0] clr_mask,
  output logic [CW-1:0] ctrl_next,
  output logic [N-1:0]  tmr_stop
);

  logic clr_go;

  assign clr_go    = clr_wr && unlocked;
  assign clr_mask  = clr_go ? wbits : '0;
  assign ctrl_next = ctrl_q & ~clr_mask;

  for (genvar i = 0; i < N; i++) begin : g_stop
    // enable is the lowest bit of each timer's group
    assign tmr_stop[i] = ctrl_q[i*CB] && !ctrl_next[i*CB];

    assert_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_stop[i] |-> (clr_wr && unlocked && wbits[i*CB]));
  end

  assert_locked_noclr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |-> (clr_mask == '0 && ctrl_next == ctrl_q));

  assert_only_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_next & ~ctrl_q) == '0);

endmodule

// File: rtl/timer_ctl_guard.sv
module timer_ctl_guard #(
  parameter int            N_TMR     = 8,
  parameter int            CTL_BITS  = 4,
  parameter int            AW        = 8,
  parameter int            DW        = 32,
  parameter bit            PROTECTED = 1'b1,
  parameter logic [AW-1:0] STS_OFS   = 'h34,
  parameter logic [AW-1:0] LOCK_OFS  = 'h38,
  parameter logic [AW-1:0] CLR_OFS   = 'h3C,
  parameter logic [7:0]    OPEN_CODE = 8'hAE,
  parameter logic [7:0]    SHUT_CODE = 8'hEA,
  localparam int           CW        = N_TMR * CTL_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [AW-1:0]       addr,
  input  logic [DW-1:0]       wdata,
  output logic [DW-1:0]       rd_data,
  input  logic [CW-1:0]       ctrl_q,
  input  logic [N_TMR-1:0]    irq_evt,
  output logic [CW-1:0]       clr_mask,
  output logic [CW-1:0]       ctrl_next,
  output logic [N_TMR-1:0]    tmr_stop,
  output logic                lock_open,
  output logic [N_TMR-1:0]    irq_sts
);

  // decoded bus events, kept as named wires for the checks
  logic hit_lock, hit_clr, hit_sts;
  logic lock_wr, clr_wr, sts_wr;

  assign hit_lock = (addr == LOCK_OFS);
  assign hit_clr  = (addr == CLR_OFS);
  assign hit_sts  = (addr == STS_OFS);
  assign lock_wr  = wr_en && hit_lock && PROTECTED;
  assign clr_wr   = wr_en && hit_clr;
  assign sts_wr   = wr_en && hit_sts && !PROTECTED;

  if (PROTECTED) begin : g_lock
    timer_clr_lock #(
      .OPEN_CODE (OPEN_CODE),
      .SHUT_CODE (SHUT_CODE)
    ) u_lock (
      .clk        (clk),
      .rst_n      (rst_n),
      .lock_wr    (lock_wr),
      .wdata_lo   (wdata[8:0]),
      .unlocked_q (lock_open)
    );
  end else begin : g_nolock
    assign lock_open = 1'b1;
  end

  timer_irq_sts #(.N(N_TMR)) u_sts (
    .clk     (clk),
    .rst_n   (rst_n),
    .sts_wr  (sts_wr),
    .wmask   (wdata[N_TMR-1:0]),
    .irq_evt (irq_evt),
    .sts_q   (irq_sts)
  );

  timer_clr_apply #(.N(N_TMR), .CB(CTL_BITS)) u_apply (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_wr    (clr_wr),
    .unlocked  (lock_open),
    .wbits     (wdata[CW-1:0]),
    .ctrl_q    (ctrl_q),
    .clr_mask  (clr_mask),
    .ctrl_next (ctrl_next),
    .tmr_stop  (tmr_stop)
  );

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      if (PROTECTED && hit_lock)      rd_data[0] = lock_open;
      else if (!PROTECTED && hit_sts) rd_data[N_TMR-1:0] = irq_sts;
    end
  end

  assert_lock_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && hit_lock) |-> (rd_data[DW-1:1] == '0));

  assert_sts_guarded_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (PROTECTED && !(|irq_evt)) |=> $stable(irq_sts));

  assert_open_always_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!PROTECTED && clr_wr) |-> (clr_mask == wdata[CW-1:0]));

endmodule

// File: tb/test_timer_ctl_guard.sv
`timescale 1ns/1ps
module test_timer_ctl_guard;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, ctrl_q = '0;
  logic [7:0]  irq_evt = '0;

  logic [31:0] rd_p, rd_o, mask_p, mask_o, nxt_p, nxt_o;
  logic [7:0]  stop_p, stop_o, sts_p, sts_o;
  logic        lock_p, lock_o;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  bit       m_unl = 0;
  bit [7:0] m_sts_p = 0, m_sts_o = 0;

  always #2.5 clk = ~clk;

  timer_ctl_guard #(.PROTECTED(1'b1)) i_timer_ctl_guard (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rd_data(rd_p), .ctrl_q(ctrl_q), .irq_evt(irq_evt),
    .clr_mask(mask_p), .ctrl_next(nxt_p), .tmr_stop(stop_p),
    .lock_open(lock_p), .irq_sts(sts_p));

  timer_ctl_guard #(.PROTECTED(1'b0)) i_timer_ctl_guard_open (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rd_data(rd_o), .ctrl_q(ctrl_q), .irq_evt(irq_evt),
    .clr_mask(mask_o), .ctrl_next(nxt_o), .tmr_stop(stop_o),
    .lock_open(lock_o), .irq_sts(sts_o));

  function automatic void chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endfunction

  task automatic cyc(string req, bit wr, bit rd, logic [7:0] a, logic [31:0] wd,
                     logic [31:0] cq, logic [7:0] ev);
    logic [31:0] em_p, em_o, er_p, er_o;
    logic [7:0]  es_p, es_o;
    @(negedge clk);
    // registered state against the model, every cycle
    chk("R2", "lock_p", {31'd0, lock_p}, {31'd0, m_unl});
    chk("R8", "lock_o", {31'd0, lock_o}, 32'd1);
    chk("R10", "sts_p", {24'd0, sts_p}, {24'd0, m_sts_p});
    chk("R10", "sts_o", {24'd0, sts_o}, {24'd0, m_sts_o});
    wr_en = wr; rd_en = rd; addr = a; wdata = wd; ctrl_q = cq; irq_evt = ev;
    #1;
    em_p = (wr && a == 8'h3C && m_unl) ? wd : 32'd0;
    em_o = (wr && a == 8'h3C) ? wd : 32'd0;
    for (int i = 0; i < 8; i++) begin
      es_p[i] = cq[4*i] & em_p[4*i];
      es_o[i] = cq[4*i] & em_o[4*i];
    end
    er_p = (rd && a == 8'h38) ? {31'd0, m_unl} : 32'd0;
    er_o = (rd && a == 8'h34) ? {24'd0, m_sts_o} : 32'd0;
    chk(req, "mask_p", mask_p, em_p);
    chk(req, "mask_o", mask_o, em_o);
    chk(req, "next_p", nxt_p, cq & ~em_p);
    chk(req, "next_o", nxt_o, cq & ~em_o);
    chk(req, "stop_p", {24'd0, stop_p}, {24'd0, es_p});
    chk(req, "stop_o", {24'd0, stop_o}, {24'd0, es_o});
    chk(req, "rd_p", rd_p, er_p);
    chk(req, "rd_o", rd_o, er_o);
    // model update for the coming edge
    if (wr && a == 8'h38) begin
      if (wd[8:1] == 8'hAE) m_unl = 1;
      else if (wd[8:1] == 8'hEA) m_unl = 0;
    end
    m_sts_p = m_sts_p | ev;
    m_sts_o = ((wr && a == 8'h34) ? (m_sts_o & wd[7:0]) : m_sts_o) | ev;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, read of lock register
    cyc("R1", 0, 1, 8'h38, 0, 32'hFFFF_FFFF, 0);
    chk("R1", "lock after reset", {31'd0, lock_p}, 32'd0);
    chk("R1", "sts after reset", {24'd0, sts_p | sts_o}, 32'd0);
    // R6: clear while locked
    cyc("R6", 1, 0, 8'h3C, 32'h0000_00FF, 32'hFFFF_FFFF, 0);
    // R4: codes in the wrong bit position, other command
    cyc("R4", 1, 0, 8'h38, 32'h0000_00AE, 0, 0);
    cyc("R4", 1, 0, 8'h38, 32'h0000_0055 << 1, 0, 0);
    // R2: unlock, then read with junk
    cyc("R2", 1, 0, 8'h38, 32'hFFFF_FE00 | (32'hAE << 1), 0, 0);
    cyc("R5", 0, 1, 8'h38, 0, 0, 0);
    cyc("R4", 1, 0, 8'h38, 32'h0000_00EA, 0, 0);
    cyc("R5", 0, 1, 8'h38, 0, 0, 0);
    // R7: accepted clear, stops for timers 0,1,3
    cyc("R7", 1, 0, 8'h3C, 32'h0000_1011, 32'hFFFF_FFFF, 0);
    cyc("R7", 1, 0, 8'h3C, 32'hF0F0_0001, 32'h1111_0110, 0);
    cyc("R6", 1, 0, 8'h3C, 32'h8000_0000, 32'h8000_0000, 0);
    // R3: relock, then clear ignored in protected mode, applied in open mode (R8)
    cyc("R3", 1, 0, 8'h38, 32'hEA << 1, 0, 0);
    cyc("R8", 1, 0, 8'h3C, 32'h1111_1111, 32'hFFFF_FFFF, 0);
    cyc("R5", 0, 1, 8'h38, 0, 0, 0);
    // R10: events, R9 status read and AND write
    cyc("R10", 0, 0, 0, 0, 0, 8'hA5);
    cyc("R9", 0, 1, 8'h34, 0, 0, 8'h02);
    cyc("R9", 1, 0, 8'h34, 32'hFFFF_FF0F, 0, 0);
    cyc("R9", 0, 1, 8'h34, 0, 0, 0);
    // R10: set wins over AND-clear on the same bit
    cyc("R10", 1, 0, 8'h34, 32'h0, 0, 8'h01);
    cyc("R9", 0, 1, 8'h34, 0, 0, 0);
    // R11: 0x34 inert in protected mode, 0x38 inert in open mode
    cyc("R11", 0, 1, 8'h34, 0, 0, 0);
    cyc("R11", 1, 0, 8'h38, 32'hAE << 1, 0, 0);
    cyc("R11", 0, 1, 8'h38, 0, 0, 0);
    // R12: other offsets and idle reads
    cyc("R12", 0, 1, 8'h30, 0, 32'h1234_5678, 0);
    cyc("R12", 0, 0, 8'h38, 0, 0, 0);
    cyc("R12", 1, 0, 8'h3D, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
    cyc("R12", 0, 0, 0, 0, 0, 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule